// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block performs multiply-accumulate into a 32-bit accumulator. It has one signed 17x17 multiplier stage and a three-stage pipeline: operand capture, multiply, and accumulate. Each operation presents two 32-bit source words and an opcode. For a half-word (word) operation, a select bit per source picks the upper or lower half of that source. A longword operation feeds the same multiplier with partial half-word products over several consecutive cycles. The partial products are summed into a 64-bit product, and only then is the product accumulated.

Each operation carries a 4-bit mode and a 2-bit product-shift code, and it adds or subtracts its product. The accumulator updates the negative, zero and sticky overflow flags. A ready signal paces issue. It stays high for word operations and drops while a longword operation still needs the multiplier. A write port loads the accumulator. A read port reports the accumulator as valid only once nothing is in flight.

Top module: `mac_pipe`

## Requirements
- R1: A word operation accepted on clock edge k multiplies two 16-bit operands. Its result is written to the accumulator on edge k+2.
- R2: The `op_x_hi`/`op_y_hi` bits select bits [31:16] of their source when 1 and bits [15:0] when 0. The selection applies to word operations only.
- R3: A longword integer operation (`op_long`=1, fractional mode bit 0) accumulates the low 32 bits of the full 32x32 product on edge k+4. `op_ready` is low after edges k and k+1 and high again after edge k+2.
- R4: A longword fractional operation forms the 64-bit product shifted left by one and keeps its upper 32 bits. With the round bit set, the lower 32 bits round to nearest and a tie goes to the even value; with the round bit clear they are truncated. The result lands on edge k+5, and `op_ready` is low after edges k, k+1 and k+2.
- R5: Word operations are accepted on every cycle, and `op_ready` stays high after each of them.
- R6: The shift code `op_shift` acts on the 32-bit product term before accumulation. 01 shifts it left by one. 10 shifts it right by one, arithmetically for signed operands and logically for unsigned ones. 00 and 11 leave it unchanged.
- R7: `op_sub`=1 subtracts the product term from the accumulator and `op_sub`=0 adds it.
- R8: The mode bits are: bit0 saturation enable, bit1 unsigned operands, bit2 fractional format, bit3 round. A fractional word product is shifted left by one to align it.
- R9: When an accumulation overflows and saturation is enabled, the result clamps to 0x7FFFFFFF or 0x80000000 (signed) or to 0xFFFFFFFF or 0x00000000 (unsigned), in the direction of the overflow. With saturation disabled the result wraps modulo 2^32.
- R10: Every retired operation sets N to result bit 31 and Z to (result == 0). V is set by an overflow and stays set through later operations.
- R11: `acc_wr` loads `acc_wdata` into the accumulator on the next edge and clears N, Z and V. A write takes precedence over a retiring operation. After reset the accumulator and all flags are 0.
- R12: `rd_valid` equals `rd_req` when no operation is in the pipeline and is 0 otherwise. `rd_data` carries the accumulator.
- R13: An operation offered while `op_ready` is low is held by the source and is accepted once ready rises. None is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation this cycle |
| op_long | input | 1 | 1: 32x32 longword, 0: 16x16 word |
| op_sub | input | 1 | 1: subtract product, 0: add |
| op_shift | input | 2 | Product shift code |
| op_mode | input | 4 | Saturate, unsigned, fractional, round |
| op_x | input | 32 | First source word |
| op_y | input | 32 | Second source word |
| op_x_hi | input | 1 | Upper-half select for op_x (word) |
| op_y_hi | input | 1 | Upper-half select for op_y (word) |
| acc_wr | input | 1 | Load accumulator |
| acc_wdata | input | 32 | Accumulator load value |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read value is settled |
| rd_data | output | 32 | Accumulator value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sticky overflow flag |

## Verification
A word result is due two edges after the edge that accepts it, a longword integer result four edges after, and a longword fractional result five edges after. A load lands one edge after `acc_wr`. The behavioural model in the bench stamps each operation with the edge it is due on. Every falling edge, it retires the operations whose edge has passed and compares the accumulator, flags, ready and read-valid. One directed check reads the accumulator on each of the three falling edges that follow an acceptance, so a one-cycle slip in either direction is caught.

// File: rtl/mac_pipe.sv
`timescale 1ns/1ps
module mac_pipe #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic         op_long,
  input  logic         op_sub,
  input  logic [1:0]   op_shift,
  input  logic [3:0]   op_mode,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         op_x_hi,
  input  logic         op_y_hi,
  input  logic         acc_wr,
  input  logic [W-1:0] acc_wdata,
  input  logic         rd_req,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;
  localparam int MW = 2 * H + 2;

  function automatic logic [H:0] ext(input logic [H-1:0] h, input logic sx);
    return {sx & h[H-1], h};
  endfunction

  logic [1:0]   rem, pidx;
  logic [W-1:0] hx, hy;
  logic         s1_v, s1_first, s1_last;
  logic [H:0]   s1_a, s1_b;
  logic [1:0]   s1_sh;
  logic [7:0]   s1_c;
  logic         s2_v;
  logic [PW-1:0] s2_sum;
  logic [7:0]   s2_c;
  logic [W-1:0] acc;

  wire accept = op_valid & op_ready;
  wire sx_new = ~op_mode[1];
  wire sx_cur = ~s1_c[1];
  assign op_ready = (rem == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0;
      s1_a <= '0; s1_b <= '0; s1_sh <= '0; s1_c <= '0;
      rem <= '0; pidx <= '0; hx <= '0; hy <= '0;
    end else if (accept) begin
      s1_v <= 1'b1;
      s1_first <= 1'b1;
      s1_sh <= 2'd0;
      s1_c <= {op_long, op_sub, op_shift, op_mode};
      if (op_long) begin
        s1_a <= ext(op_x[H-1:0], 1'b0);
        s1_b <= ext(op_y[H-1:0], 1'b0);
        s1_last <= 1'b0;
        rem <= op_mode[2] ? 2'd3 : 2'd2;
        pidx <= 2'd1;
        hx <= op_x;
        hy <= op_y;
      end else begin
        s1_a <= ext(op_x_hi ? op_x[W-1:H] : op_x[H-1:0], sx_new);
        s1_b <= ext(op_y_hi ? op_y[W-1:H] : op_y[H-1:0], sx_new);
        s1_last <= 1'b1;
      end
    end else if (rem != 2'd0) begin
      s1_v <= 1'b1;
      s1_first <= 1'b0;
      s1_last <= (rem == 2'd1);
      rem <= rem - 2'd1;
      pidx <= pidx + 2'd1;
      case (pidx)
        2'd1: begin
          s1_a <= ext(hx[H-1:0], 1'b0);
          s1_b <= ext(hy[W-1:H], sx_cur);
          s1_sh <= 2'd1;
        end
        2'd2: begin
          s1_a <= ext(hx[W-1:H], sx_cur);
          s1_b <= ext(hy[H-1:0], 1'b0);
          s1_sh <= 2'd1;
        end
        default: begin
          s1_a <= ext(hx[W-1:H], sx_cur);
          s1_b <= ext(hy[W-1:H], sx_cur);
          s1_sh <= 2'd2;
        end
      endcase
    end else begin
      s1_v <= 1'b0;
    end
  end

  wire signed [MW-1:0] mul = $signed(s1_a) * $signed(s1_b);
  wire [PW-1:0] mul_x = {{(PW-MW){mul[MW-1]}}, mul};
  wire [PW-1:0] pp = (s1_sh == 2'd0) ? mul_x :
                     (s1_sh == 2'd1) ? (mul_x << H) : (mul_x << W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_sum <= '0; s2_c <= '0;
    end else begin
      s2_v <= s1_v & s1_last;
      if (s1_v) begin
        s2_sum <= s1_first ? pp : s2_sum + pp;
        s2_c <= s1_c;
      end
    end
  end

  wire       lng  = s2_c[7];
  wire       sub  = s2_c[6];
  wire [1:0] sh   = s2_c[5:4];
  wire       rnd  = s2_c[3];
  wire       frac = s2_c[2];
  wire       uns  = s2_c[1];
  wire       sat  = s2_c[0];

  wire [PW-1:0] fl = s2_sum << 1;
  wire rinc = rnd & fl[W-1] & ((|fl[W-2:0]) | fl[W]);

  logic [W-1:0] base, pv, satv, res;
  logic [W+1:0] ax, px, sum;
  logic         ovf;

  always_comb begin
    if (lng & frac)  base = fl[PW-1:W] + W'(rinc);
    else if (frac)   base = {s2_sum[W-2:0], 1'b0};
    else             base = s2_sum[W-1:0];
    case (sh)
      2'd1:    pv = base << 1;
      2'd2:    pv = {~uns & base[W-1], base[W-1:1]};
      default: pv = base;
    endcase
    ax  = {{2{~uns & acc[W-1]}}, acc};
    px  = {{2{~uns & pv[W-1]}}, pv};
    sum = sub ? ax - px : ax + px;
    if (uns) ovf = (sum[W+1:W] != 2'b00);
    else     ovf = (sum[W+1:W-1] != 3'b000) && (sum[W+1:W-1] != 3'b111);
    if (uns) satv = sum[W+1] ? '0 : '1;
    else     satv = sum[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    res = (ovf & sat) ? satv : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0;
    end else if (acc_wr) begin
      acc <= acc_wdata;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0;
    end else if (s2_v) begin
      acc <= res;
      flag_n <= res[W-1];
      flag_z <= (res == '0);
      flag_v <= flag_v | ovf;
    end
  end

  assign rd_data  = acc;
  assign rd_valid = rd_req & ~s1_v & ~s2_v;

  // R3
  long_int_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_long && !op_mode[2] |=> !op_ready ##1 !op_ready ##1 op_ready);
  // R4
  long_frac_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_long && op_mode[2] |=> !op_ready ##1 !op_ready ##1 !op_ready ##1 op_ready);
  // R5
  word_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !op_long |=> op_ready);
  // R9
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && !acc_wr && sat && ovf |=>
      (rd_data == 32'h7FFFFFFF || rd_data == 32'h80000000 ||
       rd_data == 32'h00000000 || rd_data == 32'hFFFFFFFF));
  // R10
  v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v && !acc_wr |=> flag_v);
  // R10
  z_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v && !acc_wr |=> flag_z == (rd_data == '0));
  // R11
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> rd_data == $past(acc_wdata) && !flag_n && !flag_z && !flag_v);
  // R12
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rd_valid);
endmodule

// File: tb/mac_pipe_tb.sv
`timescale 1ns/1ps
module mac_pipe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_long = 1'b0, op_sub = 1'b0, op_x_hi = 1'b0, op_y_hi = 1'b0;
  logic [1:0] op_shift = 2'd0;
  logic [3:0] op_mode = 4'd0;
  logic [31:0] op_x = '0, op_y = '0, acc_wdata = '0;
  logic acc_wr = 1'b0, rd_req = 1'b1;
  logic op_ready, rd_valid, flag_n, flag_z, flag_v;
  logic [31:0] rd_data;

  mac_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_long(op_long), .op_sub(op_sub), .op_shift(op_shift), .op_mode(op_mode),
    .op_x(op_x), .op_y(op_y), .op_x_hi(op_x_hi), .op_y_hi(op_y_hi),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] x, y;
    bit xh, yh, lng, sub;
    bit [1:0] sh;
    bit [3:0] mode;
    int ret;
  } op_t;

  op_t q[$];
  int cyc = 0;
  int busy_until = 0;
  int nchk = 0, nfail = 0;
  bit wr_pend = 0;
  int wr_edge = 0;
  logic [31:0] wr_val;
  logic [31:0] m_acc = '0;
  bit m_n = 0, m_z = 0, m_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic apply_op(op_t o);
    logic [15:0] a16, b16;
    logic [63:0] full, f;
    logic [31:0] p, r;
    longint ax, px, s;
    bit ov;
    a16 = o.xh ? o.x[31:16] : o.x[15:0];
    b16 = o.yh ? o.y[31:16] : o.y[15:0];
    if (!o.lng) begin
      if (o.mode[1]) full = {48'b0, a16} * {48'b0, b16};
      else full = longint'($signed(a16)) * longint'($signed(b16));
      if (o.mode[2]) p = {full[30:0], 1'b0}; else p = full[31:0];
    end else begin
      if (o.mode[1]) full = {32'b0, o.x} * {32'b0, o.y};
      else full = longint'($signed(o.x)) * longint'($signed(o.y));
      if (!o.mode[2]) p = full[31:0];
      else begin
        f = full << 1;
        p = f[63:32];
        if (o.mode[3] && (f[31:0] > 32'h80000000 || (f[31:0] == 32'h80000000 && f[32])))
          p = p + 1;
      end
    end
    if (o.sh == 2'd1) p = p << 1;
    else if (o.sh == 2'd2) begin
      if (o.mode[1]) p = p >> 1; else p = {p[31], p[31:1]};
    end
    if (o.mode[1]) begin ax = longint'({32'b0, m_acc}); px = longint'({32'b0, p}); end
    else begin ax = longint'($signed(m_acc)); px = longint'($signed(p)); end
    s = o.sub ? ax - px : ax + px;
    if (o.mode[1]) ov = (s < 0) || (s > 64'sd4294967295);
    else ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    r = s[31:0];
    if (ov && o.mode[0]) begin
      if (o.mode[1]) r = (s < 0) ? 32'h0 : 32'hFFFFFFFF;
      else r = (s < 0) ? 32'h80000000 : 32'h7FFFFFFF;
    end
    m_acc = r; m_n = r[31]; m_z = (r == 0); m_v = m_v | ov;
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_pend && wr_edge <= cyc) begin
        m_acc = wr_val; m_n = 0; m_z = 0; m_v = 0; wr_pend = 0;
      end
      while (q.size() > 0 && q[0].ret <= cyc) apply_op(q.pop_front());
      chk("R1 accumulator", rd_data, m_acc);
      chk("R10 flags", {29'b0, flag_n, flag_z, flag_v}, {29'b0, m_n, m_z, m_v});
      chk("R5 ready", {31'b0, op_ready}, {31'b0, (cyc >= busy_until)});
      chk("R12 read valid", {31'b0, rd_valid}, {31'b0, rd_req && q.size() == 0});
    end
  end

  task automatic send(logic [31:0] x, logic [31:0] y, bit xh, bit yh,
                      bit lng, bit sub, bit [1:0] sh, bit [3:0] mode);
    op_t o;
    int lat, passes;
    @(negedge clk); #1;
    op_x = x; op_y = y; op_x_hi = xh; op_y_hi = yh;
    op_long = lng; op_sub = sub; op_shift = sh; op_mode = mode; op_valid = 1'b1;
    while (!op_ready) begin @(negedge clk); #1; end
    lat = !lng ? 2 : (mode[2] ? 5 : 4);
    passes = !lng ? 1 : (mode[2] ? 4 : 3);
    o.x = x; o.y = y; o.xh = xh; o.yh = yh; o.lng = lng; o.sub = sub;
    o.sh = sh; o.mode = mode; o.ret = cyc + 1 + lat;
    q.push_back(o);
    busy_until = cyc + passes;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); #1;
    acc_wr = 1'b1; acc_wdata = v;
    wr_val = v; wr_edge = cyc + 1; wr_pend = 1;
    @(posedge clk); #1;
    acc_wr = 1'b0;
  endtask

  task automatic drain();
    repeat (7) @(negedge clk);
    #2;
  endtask

  int c0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R11 reset accumulator", rd_data, 32'h0);
    chk("R11 reset flags", {29'b0, flag_n, flag_z, flag_v}, 32'h0);
    chk("R5 reset ready", {31'b0, op_ready}, 32'h1);

    // R1 R2 latency and half select
    wr(32'h10);
    send(32'h0007_0003, 32'h0005_0002, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0000);
    @(negedge clk); #2; chk("R1 edge k", rd_data, 32'h10);
    @(negedge clk); #2; chk("R1 edge k+1", rd_data, 32'h10);
    @(negedge clk); #2; chk("R2 result at k+2", rd_data, 32'h1F);

    // R5 back-to-back word issue
    wr(32'h0);
    c0 = cyc;
    for (int i = 1; i <= 4; i++)
      send(i, i, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000);
    chk("R5 one cycle per word op", cyc - c0, 32'd4);
    drain(); chk("R5 sum of squares", rd_data, 32'd30);

    // R6 product shift
    wr(32'h0);
    send(32'd6, 32'd5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0000);
    send(32'h0000_FFF9, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'b0000);
    send(32'd2, 32'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 4'b0000);
    drain(); chk("R6 shifted products", rd_data, 32'd56 + 32'd6);

    // R7 subtract
    wr(32'd100);
    send(32'd7, 32'd8, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0000);
    drain(); chk("R7 subtract", rd_data, 32'd44);

    // R3 longword integer
    wr(32'h0);
    send(32'h0001_2345, 32'h0001_0002, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0000);
    drain(); chk("R3 low 32 bits", rd_data, 32'h2347_468A);

    // R13 word offered while longword busy
    wr(32'h0);
    send(32'h0001_2345, 32'h0001_0002, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0000);
    send(32'd3, 32'd5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000);
    drain(); chk("R13 held op retired", rd_data, 32'h2347_4699);

    // R4 fractional longword rounding
    wr(32'h0);
    send(32'h0001_8000, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b1100);
    drain(); chk("R4 tie rounds to even 2", rd_data, 32'd2);
    send(32'h0001_8000, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b0100);
    send(32'h0000_8000, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'b1100);
    drain(); chk("R4 truncate and even tie", rd_data, 32'd3);

    // R8 fractional word alignment
    wr(32'h0);
    send(32'h0000_4000, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0100);
    drain(); chk("R8 fractional word", rd_data, 32'h2000_0000);

    // R9 saturation and wrap
    wr(32'h7FFF_FFF0);
    send(32'h100, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0001);
    drain(); chk("R9 signed clamp", rd_data, 32'h7FFF_FFFF);
    chk("R10 V set", {31'b0, flag_v}, 32'h1);
    wr(32'h7FFF_FFF0);
    send(32'h100, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000);
    drain(); chk("R9 signed wrap", rd_data, 32'h8000_FFF0);
    chk("R10 N after wrap", {31'b0, flag_n}, 32'h1);
    wr(32'd5);
    send(32'd3, 32'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0011);
    drain(); chk("R9 unsigned clamp", rd_data, 32'h0);
    chk("R10 Z V", {30'b0, flag_z, flag_v}, 32'h3);
    send(32'd1, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0011);
    drain(); chk("R10 V sticky", {30'b0, flag_z, flag_v}, 32'h1);

    // R11 write clears flags
    wr(32'h0);
    @(negedge clk); #2;
    chk("R11 flags cleared", {29'b0, flag_n, flag_z, flag_v}, 32'h0);

    // R12 read port
    rd_req = 1'b0;
    @(negedge clk); #2; chk("R12 no request", {31'b0, rd_valid}, 32'h0);
    rd_req = 1'b1;
    @(negedge clk); #2; chk("R12 idle valid", {31'b0, rd_valid}, 32'h1);
    send(32'd2, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000);
    chk("R12 blocked in flight", {31'b0, rd_valid}, 32'h0);
    drain();

    // mixed random traffic against the model
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin drain(); wr($urandom); end
      send($urandom, $urandom, 1'($urandom), 1'($urandom), ($urandom % 3) == 0,
           1'($urandom), 2'($urandom), 4'($urandom));
    end
    drain();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule